// File: doc/BRIEF.md
# Active Phone List Merger

This block gathers the phones that must be active in the next recognition frame. Two producers feed it. One sends phones that stay active after the current frame's scoring. The other sends phones that have just become reachable from the grammar side. Either producer may offer a phone that has already arrived during the frame, and the grammar side may offer the same phone many times. The block keeps one entry per phone identifier. Each entry holds the best start score seen so far, where a lower negative-log value is better.

Incoming phones go to a table addressed by phone identifier. The table holds a valid bit and a score for each phone. A separate order list records each identifier the first time it appears. When a frame-end pulse arrives, the block stops accepting input. It then replays the order list one entry per cycle, clears each table slot as it reads it, and raises a one-cycle done pulse after the last entry. The table is then empty for the next frame.

Top module: `phone_list_merger`

## Requirements
- R1: After reset, `out_valid` and `done` are low and both `vit_ready` and `gram_ready` are high.
- R2: While collecting, if both inputs are valid in the same cycle, the continuing input is accepted (`vit_ready` high) and the grammar input is stalled (`gram_ready` low). The grammar input is accepted once the continuing input is idle.
- R3: A phone identifier that has no entry yet in the current frame creates a new entry. The readout lists the entries in the order in which their identifiers first arrived.
- R4: An arrival for a phone that already has an entry replaces the stored score only when the new score is strictly lower. The readout therefore carries the minimum score presented for that phone during the frame.
- R5: Arrivals of one phone from both inputs, and repeated arrivals from the grammar input, produce exactly one readout entry for that phone.
- R6: Collecting a frame-end pulse starts the readout. The first entry appears on `out_valid`/`out_id`/`out_score` one cycle after the edge that samples the pulse, and the following entries appear on consecutive cycles.
- R7: `done` is high for exactly one cycle, in the cycle after the last entry. With an empty list it is high in the cycle after the frame-end edge. `done` and `out_valid` are never high together.
- R8: From the frame-end edge until `done`, both ready outputs are low, and input valids have no effect on any list.
- R9: A frame-end pulse that arrives during readout is ignored.
- R10: After `done`, the table is empty. A phone from the previous frame starts a fresh entry and takes any score, including a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vit_valid | input | 1 | Continuing phone offered |
| vit_ready | output | 1 | Continuing phone accepted this cycle |
| vit_id | input | ID_W | Continuing phone identifier |
| vit_score | input | SCORE_W | Continuing phone start score |
| gram_valid | input | 1 | Grammar-activated phone offered |
| gram_ready | output | 1 | Grammar phone accepted this cycle |
| gram_id | input | ID_W | Grammar phone identifier |
| gram_score | input | SCORE_W | Grammar phone start score |
| frame_end | input | 1 | Pulse that closes the frame and starts readout |
| out_valid | output | 1 | Readout entry present |
| out_id | output | ID_W | Readout phone identifier |
| out_score | output | SCORE_W | Readout best start score |
| done | output | 1 | One-cycle pulse after the last readout entry |

## Verification
The bench builds the block with `ID_W = 4` and `SCORE_W = 8`, which gives a 16-phone table. This small size lets one frame fill every slot, so the full-list case and the order list's wrap boundary are both exercised. Score sequences computed arithmetically push many repeated identifiers through each input. This covers both replacing and keeping a stored score, and arrivals from both inputs in the same cycle. Further frames cover an empty list, stray input and a stray frame-end during readout, and reuse of an identifier with a higher score after a frame closes.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } plm_state_e;
endpackage

// File: rtl/plm_arbiter.sv
module plm_arbiter (
  input  logic collect,
  input  logic vit_valid,
  input  logic gram_valid,
  output logic vit_ready,
  output logic gram_ready,
  output logic acc_en,
  output logic acc_vit
);
  always_comb begin
    vit_ready  = collect;
    gram_ready = collect && !vit_valid;
    acc_vit    = collect && vit_valid;
    acc_en     = acc_vit || (gram_ready && gram_valid);
  end
endmodule

// File: rtl/plm_score_table.sv
module plm_score_table #(
  parameter int ID_W    = 8,
  parameter int SCORE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic [ID_W-1:0]    upd_id,
  input  logic [SCORE_W-1:0] upd_score,
  output logic               upd_new,
  input  logic               clr_en,
  input  logic [ID_W-1:0]    clr_id,
  output logic [SCORE_W-1:0] clr_score
);
  localparam int DEPTH = 1 << ID_W;

  logic [DEPTH-1:0]   vbit;
  logic [SCORE_W-1:0] smem [DEPTH];
  logic               wr_score;

  always_comb begin
    upd_new   = !vbit[upd_id];
    wr_score  = upd_en && (upd_new || (upd_score < smem[upd_id]));
    clr_score = smem[clr_id];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbit <= '0;
    end else begin
      if (upd_en)
        vbit[upd_id] <= 1'b1;
      if (clr_en)
        vbit[clr_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_score)
      smem[upd_id] <= upd_score;
  end
endmodule

// File: rtl/plm_order_list.sv
module plm_order_list #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_idx,
  input  logic [ID_W-1:0] wr_id,
  input  logic [ID_W-1:0] rd_idx,
  output logic [ID_W-1:0] rd_id
);
  localparam int DEPTH = 1 << ID_W;

  logic [ID_W-1:0] omem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      omem[wr_idx] <= wr_id;
  end

  assign rd_id = omem[rd_idx];
endmodule

// File: rtl/phone_list_merger.sv
module phone_list_merger
  import plm_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int SCORE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vit_valid,
  output logic               vit_ready,
  input  logic [ID_W-1:0]    vit_id,
  input  logic [SCORE_W-1:0] vit_score,
  input  logic               gram_valid,
  output logic               gram_ready,
  input  logic [ID_W-1:0]    gram_id,
  input  logic [SCORE_W-1:0] gram_score,
  input  logic               frame_end,
  output logic               out_valid,
  output logic [ID_W-1:0]    out_id,
  output logic [SCORE_W-1:0] out_score,
  output logic               done
);
  localparam int CNT_W = ID_W + 1;

  plm_state_e         state;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   rd_ptr;
  logic               acc_en;
  logic               acc_vit;
  logic               upd_new;
  logic [ID_W-1:0]    upd_id;
  logic [SCORE_W-1:0] upd_score;
  logic [ID_W-1:0]    rd_id;
  logic [SCORE_W-1:0] rd_score;
  logic               drain_go;

  assign upd_id    = acc_vit ? vit_id : gram_id;
  assign upd_score = acc_vit ? vit_score : gram_score;
  assign drain_go  = (state == ST_DRAIN) && (rd_ptr != count);

  plm_arbiter arb_i (
    .collect    (state == ST_COLLECT),
    .vit_valid  (vit_valid),
    .gram_valid (gram_valid),
    .vit_ready  (vit_ready),
    .gram_ready (gram_ready),
    .acc_en     (acc_en),
    .acc_vit    (acc_vit)
  );

  plm_score_table #(.ID_W(ID_W), .SCORE_W(SCORE_W)) tbl_i (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (acc_en),
    .upd_id    (upd_id),
    .upd_score (upd_score),
    .upd_new   (upd_new),
    .clr_en    (drain_go),
    .clr_id    (rd_id),
    .clr_score (rd_score)
  );

  plm_order_list #(.ID_W(ID_W)) ord_i (
    .clk    (clk),
    .wr_en  (acc_en && upd_new),
    .wr_idx (count[ID_W-1:0]),
    .wr_id  (upd_id),
    .rd_idx (rd_ptr[ID_W-1:0]),
    .rd_id  (rd_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      count     <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_id    <= '0;
      out_score <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_COLLECT: begin
          if (acc_en && upd_new)
            count <= count + 1'b1;
          if (frame_end) begin
            state  <= ST_DRAIN;
            rd_ptr <= '0;
          end
        end
        default: begin
          if (drain_go) begin
            out_valid <= 1'b1;
            out_id    <= rd_id;
            out_score <= rd_score;
            rd_ptr    <= rd_ptr + 1'b1;
          end else begin
            done  <= 1'b1;
            count <= '0;
            state <= ST_COLLECT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/phone_list_merger_chk.sv
module phone_list_merger_chk (
  input logic clk,
  input logic rst,
  input logic vit_valid,
  input logic vit_ready,
  input logic gram_valid,
  input logic gram_ready,
  input logic frame_end,
  input logic out_valid,
  input logic done
);
  a_r2_vit_first: assert property (@(posedge clk) disable iff (rst)
    (vit_valid && vit_ready) |-> !gram_ready);

  a_r7_done_alone: assert property (@(posedge clk) disable iff (rst)
    !(done && out_valid));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_contiguous: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (out_valid || done));

  a_r8_stall_on_close: assert property (@(posedge clk) disable iff (rst)
    (frame_end && vit_ready) |=> (!vit_ready && !gram_ready));

  a_r8_stall_in_drain: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!vit_ready && !gram_ready));
endmodule

bind phone_list_merger phone_list_merger_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .vit_valid  (vit_valid),
  .vit_ready  (vit_ready),
  .gram_valid (gram_valid),
  .gram_ready (gram_ready),
  .frame_end  (frame_end),
  .out_valid  (out_valid),
  .done       (done)
);

// File: tb/phone_list_merger_tb_top.sv
`timescale 1ns/1ps
module phone_list_merger_tb_top;
  localparam int ID_W    = 4;
  localparam int SCORE_W = 8;
  localparam int NPH     = 1 << ID_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vit_valid = 1'b0, gram_valid = 1'b0, frame_end = 1'b0;
  logic [ID_W-1:0] vit_id = '0, gram_id = '0;
  logic [SCORE_W-1:0] vit_score = '0, gram_score = '0;
  logic vit_ready, gram_ready, out_valid, done;
  logic [ID_W-1:0] out_id;
  logic [SCORE_W-1:0] out_score;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit              ev [NPH];
  int              es [NPH];
  int              eord [NPH];
  int              en = 0;

  always #4 clk = ~clk;

  phone_list_merger #(.ID_W(ID_W), .SCORE_W(SCORE_W)) dut_i (
    .clk(clk), .rst(rst),
    .vit_valid(vit_valid), .vit_ready(vit_ready), .vit_id(vit_id), .vit_score(vit_score),
    .gram_valid(gram_valid), .gram_ready(gram_ready), .gram_id(gram_id), .gram_score(gram_score),
    .frame_end(frame_end),
    .out_valid(out_valid), .out_id(out_id), .out_score(out_score), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_add(input int id, input int sc);
    if (!ev[id]) begin
      ev[id] = 1'b1;
      es[id] = sc;
      eord[en] = id;
      en++;
    end else if (sc < es[id]) begin
      es[id] = sc;
    end
  endfunction

  task automatic send_vit(input int id, input int sc);
    @(negedge clk);
    vit_valid = 1'b1; vit_id = ID_W'(id); vit_score = SCORE_W'(sc);
    #1 check("R3 vit_ready while collecting", int'(vit_ready), 1);
    model_add(id, sc);
    @(negedge clk);
    vit_valid = 1'b0;
  endtask

  task automatic send_gram(input int id, input int sc);
    @(negedge clk);
    gram_valid = 1'b1; gram_id = ID_W'(id); gram_score = SCORE_W'(sc);
    #1 check("R5 gram_ready while collecting", int'(gram_ready), 1);
    model_add(id, sc);
    @(negedge clk);
    gram_valid = 1'b0;
  endtask

  task automatic send_both(input int vid, input int vs, input int gid, input int gs);
    @(negedge clk);
    vit_valid = 1'b1; vit_id = ID_W'(vid); vit_score = SCORE_W'(vs);
    gram_valid = 1'b1; gram_id = ID_W'(gid); gram_score = SCORE_W'(gs);
    #1 check("R2 vit_ready with both valid", int'(vit_ready), 1);
    check("R2 gram_ready stalled with both valid", int'(gram_ready), 0);
    model_add(vid, vs);
    @(negedge clk);
    vit_valid = 1'b0;
    #1 check("R2 gram_ready once vit idle", int'(gram_ready), 1);
    model_add(gid, gs);
    @(negedge clk);
    gram_valid = 1'b0;
  endtask

  task automatic drain_check(input bit poke, input int poke_id);
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    #1 check("R8 vit_ready low after close", int'(vit_ready), 0);
    check("R8 gram_ready low after close", int'(gram_ready), 0);
    if (poke) begin
      vit_valid = 1'b1; vit_id = ID_W'(poke_id); vit_score = '0;
      gram_valid = 1'b1; gram_id = ID_W'(poke_id); gram_score = '0;
      frame_end = 1'b1;
    end
    for (int k = 0; k < en; k++) begin
      @(negedge clk);
      vit_valid = 1'b0; gram_valid = 1'b0; frame_end = 1'b0;
      #1 check("R6 out_valid during readout", int'(out_valid), 1);
      check("R3 readout id order", int'(out_id), eord[k]);
      check("R4 readout best score", int'(out_score), es[eord[k]]);
      check("R8 readies low in readout", int'(vit_ready | gram_ready), 0);
    end
    @(negedge clk);
    vit_valid = 1'b0; gram_valid = 1'b0; frame_end = 1'b0;
    #1 check("R7 done after last entry", int'(done), 1);
    check("R7 out_valid low with done", int'(out_valid), 0);
    @(negedge clk);
    #1 check("R7 done single cycle", int'(done), 0);
    check("R9 no extra output after done", int'(out_valid), 0);
    check("R10 collecting again", int'(vit_ready), 1);
    for (int i = 0; i < NPH; i++) ev[i] = 1'b0;
    en = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NPH; i++) ev[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 vit_ready after reset", int'(vit_ready), 1);
    check("R1 gram_ready after reset", int'(gram_ready), 1);

    // Frame 1: all phones from the continuing input, then grammar duplicates
    for (int i = 0; i < NPH; i++) send_vit((i * 5) % NPH, 100 + (i * 3) % 50);
    for (int j = 0; j < 24; j++) send_gram((j * 3) % NPH, (j * 37) % 256);
    drain_check(1'b0, 0);

    // Frame 2: grammar only, heavy repetition
    for (int j = 0; j < 30; j++) send_gram((j * 7 + 2) % 6, (j * 53 + 11) % 256);
    drain_check(1'b0, 0);

    // Frame 3: empty list
    drain_check(1'b0, 0);

    // Frame 4: simultaneous arrivals, same and different phones
    for (int j = 0; j < 8; j++) send_both(j % 5, 200 - j * 9, (j * 3) % 5, 60 + j * 17);
    drain_check(1'b1, 9);

    // Frame 5: stray traffic during previous readout must be absent; reuse with higher scores
    send_vit(0, 250);
    send_gram(1, 255);
    send_gram(0, 251);
    drain_check(1'b1, 12);

    // Frame 6: single entry after stray readout traffic
    send_gram(3, 42);
    drain_check(1'b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule